// File: doc/BRIEF.md
# SPI Two-Step Chip-Select Router

This block lets one host SPI master reach several telephony port modules and a bank of bicolour status LEDs while using only two host chip selects. The host first sends one byte on the select chip select. That byte names a destination and is held in a select register. It then sends payload bytes on the data chip select. Each payload goes to the destination last named. A module destination gets its own active-low chip select, which follows the host data chip select edge for edge. The host clock and data lines are shared with every module, and the host read line is taken from the module that is selected. The LED destination is an 8-bit register inside the block, and each 2-bit field of it drives one LED.

The host SPI pins are asynchronous to the block clock `clk`. The two frame decoders oversample them through a two-stage synchronizer, so the SPI clock period must be at least about six `clk` periods. The chip select, clock, data and read paths to the modules are combinational and do not wait on the synchronizer. Port addressing uses a 3-bit port number, so up to eight ports fit in two stacked boards. The parameter `MOD_BASE` sets which port numbers this board answers to. Everything is plain SPI wiring with no stream handshake: the host cannot be stalled, and frames that break the rules are simply dropped.

Top module: `spi_cs_router`

## Requirements
- R1: After reset the select register holds 0xFF, which addresses nothing. All LEDs are off, all module chip selects are high and `host_miso` is low.
- R2: A frame on `host_sel_cs_n` is sent SPI mode 0, MSB first. It is sampled on rising `host_sck`. It loads the select register when `host_sel_cs_n` rises after exactly 8 clocks.
- R3: A select frame with any count other than 8 clocks leaves the select register unchanged.
- R4: While the select value is a module address (bits [7:3] zero and port number bits [2:0] in MOD_BASE..MOD_BASE+N_MOD-1), `mod_cs_n[port-MOD_BASE]` equals `host_dat_cs_n`. All other module chip selects stay high.
- R5: `mod_sck` and `mod_mosi` always follow `host_sck` and `host_mosi`.
- R6: While a module is addressed and `host_dat_cs_n` is low, `host_miso` equals that module's `mod_miso` bit. At all other times `host_miso` is low.
- R7: When the select value equals LED_SEL (default 0x08), an 8-clock data frame is written to the LED register on the rise of `host_dat_cs_n`. LED i uses bits [2i+1:2i]. Code 01 lights `led_red[i]`, code 10 lights `led_grn[i]`, and codes 00 and 11 leave both off. All module chip selects stay high during the frame.
- R8: A data frame to the LED register with any count other than 8 clocks leaves the LEDs unchanged.
- R9: A data frame sent while the select value addresses nothing asserts no module chip select, keeps `host_miso` low and leaves the LEDs unchanged.
- R10: The select value survives data frames, so repeated payloads reach the same destination without a new select frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock used to oversample the SPI pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_sck | input | 1 | Host SPI clock |
| host_mosi | input | 1 | Host SPI write data |
| host_sel_cs_n | input | 1 | Host chip select for the destination-select byte |
| host_dat_cs_n | input | 1 | Host chip select for payload transfers |
| host_miso | output | 1 | Read data back to the host |
| mod_sck | output | 1 | SPI clock forwarded to the modules |
| mod_mosi | output | 1 | Write data forwarded to the modules |
| mod_cs_n | output | N_MOD | Per-module active-low chip selects |
| mod_miso | input | N_MOD | Read data from each module |
| led_red | output | N_LED | Red drive per port LED |
| led_grn | output | N_LED | Green drive per port LED |

## Verification
The assertions check on every cycle that at most one module chip select is low, and that none is low while the host data chip select is high or while the LED register is addressed. They also check that `host_miso` stays low when no module is addressed, and that the select register and the LED register change only on a completed 8-clock frame. Only the bench scenarios can show the end-to-end behaviour. These are MSB-first assembly of the select byte, the routing that results for every one of the 256 select values, and the LED colour decode for every one of the 256 payloads. They also cover dropping 7- and 9-clock frames on both chip selects, and a select value persisting over several payloads.

// File: rtl/spi_rt_pkg.sv
package spi_rt_pkg;
  localparam int FRAME_BITS = 8;
  localparam int CNT_W      = $clog2(FRAME_BITS + 2);
  localparam int PORT_W     = 3;
  typedef logic [FRAME_BITS-1:0] frame_t;
  localparam frame_t SEL_NONE = '1;
endpackage

// File: rtl/spi_rt_shift.sv
module spi_rt_shift
  import spi_rt_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   cs_n,
  input  logic   cs_n_prev,
  input  logic   sck_rise,
  input  logic   mosi,
  output logic   done_o,
  output logic   ok_o,
  output frame_t data_o
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(FRAME_BITS);
  localparam logic [CNT_W-1:0] SAT  = CNT_W'(FRAME_BITS + 1);

  logic [CNT_W-1:0] cnt_q;
  frame_t           sr_q;
  logic             cs_fall;

  assign cs_fall = !cs_n && cs_n_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sr_q  <= '0;
    end else if (cs_fall) begin
      cnt_q <= '0;
    end else if (!cs_n && sck_rise) begin
      sr_q <= {sr_q[FRAME_BITS-2:0], mosi};
      if (cnt_q != SAT) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign done_o = cs_n && !cs_n_prev;
  assign ok_o   = (cnt_q == FULL);
  assign data_o = sr_q;

  // R3 / R8: bit counter saturates, never wraps back to a valid length
  a_r3_cnt_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= SAT);
endmodule

// File: rtl/spi_rt_decode.sv
module spi_rt_decode
  import spi_rt_pkg::*;
#(
  parameter int     N_MOD    = 4,
  parameter int     MOD_BASE = 0,
  parameter frame_t LED_SEL  = 8'h08
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel_wr,
  input  frame_t           sel_din,
  input  logic             dat_cs_n,
  input  logic [N_MOD-1:0] mod_miso,
  output logic [N_MOD-1:0] mod_cs_n,
  output logic             host_miso,
  output logic             led_hit
);
  frame_t            sel_q;
  logic [PORT_W-1:0] idx;
  logic              is_mod;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sel_q <= SEL_NONE;
    else if (sel_wr) sel_q <= sel_din;
  end

  assign idx    = sel_q[PORT_W-1:0] - PORT_W'(MOD_BASE);
  assign is_mod = (sel_q[FRAME_BITS-1:PORT_W] == '0) &&
                  ({1'b0, idx} < (PORT_W+1)'(N_MOD));
  assign led_hit = (sel_q == LED_SEL);

  for (genvar i = 0; i < N_MOD; i++) begin : g_cs
    assign mod_cs_n[i] = dat_cs_n || !(is_mod && (idx == PORT_W'(i)));
  end

  assign host_miso = |(~mod_cs_n & mod_miso);

  // R2: select register moves only on a completed select frame
  a_r2_sel_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_wr |=> $stable(sel_q));
  // R4: never more than one module selected
  a_r4_cs_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~mod_cs_n));
  // R7: LED destination keeps every module deselected
  a_r7_led_cs_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    led_hit |-> (&mod_cs_n));
  // R9: nothing addressed means quiet outputs
  a_r9_unaddressed_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !is_mod |-> ((&mod_cs_n) && !host_miso));
endmodule

// File: rtl/spi_rt_led.sv
module spi_rt_led
  import spi_rt_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr,
  input  frame_t                  din,
  output logic [FRAME_BITS/2-1:0] led_red,
  output logic [FRAME_BITS/2-1:0] led_grn
);
  localparam int N_LED = FRAME_BITS / 2;

  frame_t led_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  led_q <= '0;
    else if (wr) led_q <= din;
  end

  for (genvar i = 0; i < N_LED; i++) begin : g_led
    assign led_red[i] = (led_q[2*i+1 -: 2] == 2'b01);
    assign led_grn[i] = (led_q[2*i+1 -: 2] == 2'b10);
  end

  // R8: LED state only changes on an accepted write
  a_r8_led_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> $stable(led_q));
endmodule

// File: rtl/spi_cs_router.sv
module spi_cs_router
  import spi_rt_pkg::*;
#(
  parameter int     N_MOD    = 4,
  parameter int     MOD_BASE = 0,
  parameter frame_t LED_SEL  = 8'h08,
  localparam int    N_LED    = FRAME_BITS / 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_sck,
  input  logic             host_mosi,
  input  logic             host_sel_cs_n,
  input  logic             host_dat_cs_n,
  output logic             host_miso,
  output logic             mod_sck,
  output logic             mod_mosi,
  output logic [N_MOD-1:0] mod_cs_n,
  input  logic [N_MOD-1:0] mod_miso,
  output logic [N_LED-1:0] led_red,
  output logic [N_LED-1:0] led_grn
);
  // synchronizer bit order: [3]=sck [2]=mosi [1]=select cs [0]=data cs
  localparam logic [3:0] IDLE = 4'b0011;

  logic [3:0] raw, s1_q, s2_q;
  logic [2:0] prev_q;          // {sck, select cs, data cs}
  logic       sck_rise;
  logic [1:0] f_done, f_ok;    // [1]=select frame, [0]=data frame
  frame_t     f_data [2];
  logic       led_hit;

  assign raw = {host_sck, host_mosi, host_sel_cs_n, host_dat_cs_n};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q   <= IDLE;
      s2_q   <= IDLE;
      prev_q <= {IDLE[3], IDLE[1:0]};
    end else begin
      s1_q   <= raw;
      s2_q   <= s1_q;
      prev_q <= {s2_q[3], s2_q[1:0]};
    end
  end

  assign sck_rise = s2_q[3] && !prev_q[2];

  for (genvar g = 0; g < 2; g++) begin : g_frame
    spi_rt_shift u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .cs_n      (s2_q[g]),
      .cs_n_prev (prev_q[g]),
      .sck_rise  (sck_rise),
      .mosi      (s2_q[2]),
      .done_o    (f_done[g]),
      .ok_o      (f_ok[g]),
      .data_o    (f_data[g])
    );
  end

  assign mod_sck  = host_sck;
  assign mod_mosi = host_mosi;

  spi_rt_decode #(
    .N_MOD    (N_MOD),
    .MOD_BASE (MOD_BASE),
    .LED_SEL  (LED_SEL)
  ) u_decode (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel_wr    (f_done[1] && f_ok[1]),
    .sel_din   (f_data[1]),
    .dat_cs_n  (host_dat_cs_n),
    .mod_miso  (mod_miso),
    .mod_cs_n  (mod_cs_n),
    .host_miso (host_miso),
    .led_hit   (led_hit)
  );

  spi_rt_led u_led (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr      (f_done[0] && f_ok[0] && led_hit),
    .din     (f_data[0]),
    .led_red (led_red),
    .led_grn (led_grn)
  );

  // R4: idle data chip select keeps all modules deselected
  a_r4_dcs_idle: assert property (@(posedge clk) disable iff (!rst_n)
    host_dat_cs_n |-> (&mod_cs_n));
  // R5: shared lines forwarded unchanged
  a_r5_forward: assert property (@(posedge clk) disable iff (!rst_n)
    (mod_sck == host_sck) && (mod_mosi == host_mosi));
endmodule

// File: tb/spi_cs_router_test.sv
`timescale 1ns/1ps
module spi_cs_router_test;
  localparam int N_MOD = 4;
  localparam int HB    = 4;   // clk cycles per SPI half bit
  localparam logic [7:0] LED_A = 8'h08;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_sck = 1'b0, host_mosi = 1'b0;
  logic host_sel_cs_n = 1'b1, host_dat_cs_n = 1'b1;
  logic host_miso, mod_sck, mod_mosi;
  logic [N_MOD-1:0] mod_cs_n;
  logic [N_MOD-1:0] mod_miso = '0;
  logic [3:0] led_red, led_grn;

  int errors = 0, checks = 0;
  logic [7:0] exp_led = '0;
  logic [7:0] cur_sel = 8'hFF;

  always #2.5 clk = ~clk;

  spi_cs_router uut (
    .clk(clk), .rst_n(rst_n), .host_sck(host_sck), .host_mosi(host_mosi),
    .host_sel_cs_n(host_sel_cs_n), .host_dat_cs_n(host_dat_cs_n),
    .host_miso(host_miso), .mod_sck(mod_sck), .mod_mosi(mod_mosi),
    .mod_cs_n(mod_cs_n), .mod_miso(mod_miso),
    .led_red(led_red), .led_grn(led_grn)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] leds_of(input logic [7:0] v);
    logic [3:0] r, g;
    for (int i = 0; i < 4; i++) begin
      r[i] = (v[2*i+1 -: 2] == 2'b01);
      g[i] = (v[2*i+1 -: 2] == 2'b10);
    end
    return {r, g};
  endfunction

  function automatic bit is_mod(input logic [7:0] s);
    return s < 8'(N_MOD);
  endfunction

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // on_sel: use select chip select; otherwise data chip select with routing checks
  task automatic frame(input bit on_sel, input logic [7:0] b, input int nbits, input bit look);
    wclk(1);
    if (on_sel) host_sel_cs_n = 1'b0; else host_dat_cs_n = 1'b0;
    wclk(HB);
    for (int i = 0; i < nbits; i++) begin
      host_mosi = b[(7 - i) & 7];
      mod_miso  = 4'(i * 5 + 3);
      wclk(HB);
      host_sck = 1'b1;
      #1;
      if (look) begin
        logic [3:0] ecs;
        logic       emiso;
        ecs   = is_mod(cur_sel) ? ~(4'b1 << cur_sel[1:0]) : 4'hF;
        emiso = is_mod(cur_sel) ? mod_miso[cur_sel[1:0]] : 1'b0;
        chk(cur_sel == LED_A ? "R7 cs quiet" : (is_mod(cur_sel) ? "R4 cs route" : "R9 cs quiet"),
            32'(mod_cs_n), 32'(ecs));
        chk(is_mod(cur_sel) ? "R6 miso" : "R9 miso low", 32'(host_miso), 32'(emiso));
        chk("R5 forward", {mod_sck, mod_mosi}, {host_sck, host_mosi});
      end
      wclk(HB);
      host_sck = 1'b0;
    end
    wclk(HB);
    if (on_sel) host_sel_cs_n = 1'b1; else host_dat_cs_n = 1'b1;
    #1;
    if (look) chk("R4 cs released", 32'(mod_cs_n), 32'hF);
    wclk(2 * HB);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    wclk(3);
    #1;
    // R1 reset state
    chk("R1 cs", 32'(mod_cs_n), 32'hF);
    chk("R1 miso", 32'(host_miso), 32'h0);
    chk("R1 leds", 32'({led_red, led_grn}), 32'h0);
    rst_n = 1'b1;
    wclk(3);
    // R1: select register resets to nothing: data frame touches nothing
    frame(1'b0, 8'h55, 8, 1'b1);
    chk("R1 led after unaddressed", 32'({led_red, led_grn}), 32'h0);

    // R7 / R10: one select, then every payload to the LED register
    frame(1'b1, LED_A, 8, 1'b0);
    cur_sel = LED_A;
    for (int p = 0; p < 256; p++) begin
      frame(1'b0, 8'(p), 8, 1'b1);
      exp_led = 8'(p);
      chk("R7 R10 led decode", 32'({led_red, led_grn}), 32'(leds_of(exp_led)));
    end
    frame(1'b0, 8'h93, 8, 1'b1);
    exp_led = 8'h93;
    chk("R7 led pattern", 32'({led_red, led_grn}), 32'(leds_of(8'h93)));

    // R8: wrong-length LED frames ignored
    frame(1'b0, 8'h5A, 7, 1'b1);
    chk("R8 7-bit led frame", 32'({led_red, led_grn}), 32'(leds_of(exp_led)));
    frame(1'b0, 8'hA5, 9, 1'b1);
    chk("R8 9-bit led frame", 32'({led_red, led_grn}), 32'(leds_of(exp_led)));

    // R2 R4 R6 R9: sweep every select value, one payload each
    for (int v = 0; v < 256; v++) begin
      frame(1'b1, 8'(v), 8, 1'b0);
      cur_sel = 8'(v);
      frame(1'b0, 8'(v) ^ 8'hA5, 8, 1'b1);
      if (8'(v) == LED_A) exp_led = 8'(v) ^ 8'hA5;
      chk(8'(v) == LED_A ? "R2 led reselect" : "R9 led unchanged",
          32'({led_red, led_grn}), 32'(leds_of(exp_led)));
    end

    // R3: wrong-length select frames ignored; R10 repeat payloads
    frame(1'b1, 8'h02, 8, 1'b0);
    cur_sel = 8'h02;
    frame(1'b1, LED_A, 7, 1'b0);
    frame(1'b0, 8'h11, 8, 1'b1);
    frame(1'b1, LED_A, 9, 1'b0);
    frame(1'b0, 8'h22, 8, 1'b1);
    frame(1'b0, 8'h33, 8, 1'b1);
    chk("R3 short select dropped", 32'({led_red, led_grn}), 32'(leds_of(exp_led)));

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule